// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface. It takes one access request at a time, each naming a bank, a row, a column, a direction, a burst length and whether the row should close itself afterwards. It turns that request into the memory commands the device expects, one command per rising clock edge on active-low chip-select, row-strobe, column-strobe and write-enable lines, together with a bank bus and a 12-bit address bus.

For each of the four banks a tracker remembers whether a row is open and which one. A request to a closed bank opens the row and then issues the column command. A request that hits the open row goes straight to the column command. A request to a different row first closes the old row, then opens the new one. Small programmable counters hold NOP cycles on the bus until each minimum gap has passed. An interval timer flags a pending refresh. The sequencer handles that flag between requests: if any bank is open it closes all banks first, and then it issues the refresh.

Top module: `ddr_cmd_seq`

## Requirements
- R1: During and right after reset the command lines carry NOP (chip-select, row-strobe, column-strobe, write-enable = 0,1,1,1), the bank and address buses are zero, and `req_ready` is high.
- R2: Only these codes on {cs_n,ras_n,cas_n,we_n} ever appear: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, NOP 0111.
- R3: A request to a closed bank produces ACTIVE, with the bank on `cmd_ba` and the row on `cmd_addr`. The READ or WRITE follows exactly T_RCD cycles later when no other gap is running.
- R4: A request to the row already open in its bank produces the column command without any ACTIVE or PRECHARGE.
- R5: A request to an open bank holding another row produces PRECHARGE for that bank with address bit 10 low. ACTIVE for the new row follows exactly T_RP cycles later, and the column command exactly T_RCD cycles after that.
- R6: On READ and WRITE, address bits 9..0 carry the column, bit 10 carries the auto-precharge flag, and bit 11 is zero.
- R7: A column command with auto-precharge leaves its bank closed, so the next access to that bank starts with ACTIVE and no PRECHARGE. That ACTIVE comes no earlier than BL/2+T_RP cycles after the column command (exactly then when the request is already waiting).
- R8: Two column commands are at least BL/2 cycles apart, where BL is the burst length of the first; `req_blen` 0, 1 and 2 select 2, 4 and 8 (3 also selects 8). When the gap is the only limit, the spacing is exactly BL/2.
- R9: A refresh falls due every REFI cycles. It is served between requests: PRECHARGE with address bit 10 high when any bank is open (skipped if none is), then AUTO REFRESH T_RP cycles later. No other command follows within T_RFC cycles, and all banks are closed afterwards.
- R10: `req_ready` is high only when the sequencer is idle with no refresh pending. A request is taken on an edge where both `req_valid` and `req_ready` are high, and `req_ready` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 10 | Starting column |
| req_autopre | input | 1 | Close the row after the burst |
| req_blen | input | 2 | Burst length code (0:2, 1:4, 2/3:8) |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | 12 | Row or column address with auto-precharge bit 10 |

## Verification
The bench targets the decisions that depend on remembered bank state. A row hit must not reopen the row; a design that forgot open rows would insert an extra ACTIVE. A row miss needs a single-bank PRECHARGE with bit 10 low; a design that drove bit 10 high would close every bank. After auto-precharge the bank must be treated as closed; a stale tracker would issue a column command to a row the device has already shut. The bench also measures exact cycle gaps (activate to column, precharge to activate, burst spacing for BL8, auto-precharge recovery) and the refresh path with an open bank, where a missing precharge-all or a command inside the refresh recovery window would show up in the logged command stream.

// File: rtl/ddr_seq_pkg.sv
`timescale 1ns/1ps
package ddr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_NOP = 4'b0111
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_RPRE,
    ST_REF
  } seq_st_t;

endpackage

// File: rtl/ddr_gap_timer.sv
`timescale 1ns/1ps
// Minimum-gap counter: after load with N, ready again N cycles later.
module ddr_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         ready
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/ddr_bank_track.sv
`timescale 1ns/1ps
// Per-bank open flag and open row.
module ddr_bank_track #(
  parameter int NB = 4,
  parameter int RW = 12,
  localparam int BW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [BW-1:0]   set_bank,
  input  logic [RW-1:0]   set_row,
  input  logic            clr_en,
  input  logic [BW-1:0]   clr_bank,
  input  logic            clr_all,
  output logic [NB-1:0]   open_o,
  output logic [NB*RW-1:0] rows_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          is_open;
    logic [RW-1:0] row_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        is_open <= 1'b0;
        row_q   <= '0;
      end else if (clr_all || (clr_en && clr_bank == BW'(b))) begin
        is_open <= 1'b0;
      end else if (set_en && set_bank == BW'(b)) begin
        is_open <= 1'b1;
        row_q   <= set_row;
      end
    end

    assign open_o[b]            = is_open;
    assign rows_o[b*RW +: RW]   = row_q;
  end
endmodule

// File: rtl/ddr_ref_timer.sv
`timescale 1ns/1ps
// Refresh interval timer with pending flag.
module ddr_ref_timer #(
  parameter int REFI = 780,
  localparam int W = $clog2(REFI + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (cnt == W'(REFI - 1)) begin
        cnt  <= '0;
        pend <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (ack) pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_seq.sv
`timescale 1ns/1ps
module ddr_cmd_seq #(
  parameter int NB    = 4,
  parameter int RW    = 12,
  parameter int CW    = 10,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RFC = 8,
  parameter int REFI  = 780,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_bank,
  input  logic [11:0]   req_row,
  input  logic [9:0]    req_col,
  input  logic          req_autopre,
  input  logic [1:0]    req_blen,
  output logic          cmd_cs_n,
  output logic          cmd_ras_n,
  output logic          cmd_cas_n,
  output logic          cmd_we_n,
  output logic [1:0]    cmd_ba,
  output logic [11:0]   cmd_addr
);
  import ddr_seq_pkg::*;

  localparam int BW     = $clog2(NB);
  localparam int AW     = RW;
  localparam int AP_BIT = 10;

  function automatic logic [TW-1:0] half_burst(input logic [1:0] code);
    case (code)
      2'd0:    return TW'(1);
      2'd1:    return TW'(2);
      default: return TW'(4);
    endcase
  endfunction

  seq_st_t       st, st_n;
  logic          q_write, q_ap;
  logic [BW-1:0] q_bank;
  logic [RW-1:0] q_row;
  logic [CW-1:0] q_col;
  logic [1:0]    q_blen;

  cmd_t          cmd_q, cmd_n;
  logic [BW-1:0] ba_q, ba_n;
  logic [AW-1:0] addr_q, addr_n;

  logic rcd_ld, rp_ld, col_ld, rfc_ld;
  logic [TW-1:0] rp_len, col_len;
  logic rcd_rdy, rp_rdy, col_rdy, rfc_rdy;

  logic set_en, clr_en, clr_all, ref_ack, accept;
  logic [NB-1:0]    bank_open;
  logic [NB*RW-1:0] bank_rows;
  logic             ref_pend;
  logic             req_is_open, req_is_hit, any_open;

  ddr_gap_timer #(.W(TW)) u_rcd (
    .clk(clk), .rst(rst), .load(rcd_ld), .len(TW'(T_RCD)), .ready(rcd_rdy)
  );
  ddr_gap_timer #(.W(TW)) u_rp (
    .clk(clk), .rst(rst), .load(rp_ld), .len(rp_len), .ready(rp_rdy)
  );
  ddr_gap_timer #(.W(TW)) u_col (
    .clk(clk), .rst(rst), .load(col_ld), .len(col_len), .ready(col_rdy)
  );
  ddr_gap_timer #(.W(TW)) u_rfc (
    .clk(clk), .rst(rst), .load(rfc_ld), .len(TW'(T_RFC)), .ready(rfc_rdy)
  );

  ddr_bank_track #(.NB(NB), .RW(RW)) u_banks (
    .clk(clk), .rst(rst),
    .set_en(set_en), .set_bank(q_bank), .set_row(q_row),
    .clr_en(clr_en), .clr_bank(q_bank), .clr_all(clr_all),
    .open_o(bank_open), .rows_o(bank_rows)
  );

  ddr_ref_timer #(.REFI(REFI)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
  );

  assign req_ready   = (st == ST_IDLE) && !ref_pend;
  assign accept      = req_ready && req_valid;
  assign req_is_open = bank_open[req_bank];
  assign req_is_hit  = req_is_open && (bank_rows[req_bank*RW +: RW] == req_row);
  assign any_open    = |bank_open;

  always_comb begin
    st_n    = st;
    cmd_n   = CMD_NOP;
    ba_n    = '0;
    addr_n  = '0;
    rcd_ld  = 1'b0;
    rp_ld   = 1'b0;
    rp_len  = TW'(T_RP);
    col_ld  = 1'b0;
    col_len = half_burst(q_blen);
    rfc_ld  = 1'b0;
    set_en  = 1'b0;
    clr_en  = 1'b0;
    clr_all = 1'b0;
    ref_ack = 1'b0;
    case (st)
      ST_IDLE: begin
        if (ref_pend) begin
          st_n = any_open ? ST_RPRE : ST_REF;
        end else if (accept) begin
          if (req_is_hit)       st_n = ST_COL;
          else if (req_is_open) st_n = ST_PRE;
          else                  st_n = ST_ACT;
        end
      end
      ST_PRE: begin
        if (col_rdy) begin
          cmd_n  = CMD_PRE;
          ba_n   = q_bank;
          rp_ld  = 1'b1;
          clr_en = 1'b1;
          st_n   = ST_ACT;
        end
      end
      ST_ACT: begin
        if (rp_rdy && rfc_rdy) begin
          cmd_n  = CMD_ACT;
          ba_n   = q_bank;
          addr_n = q_row;
          rcd_ld = 1'b1;
          set_en = 1'b1;
          st_n   = ST_COL;
        end
      end
      ST_COL: begin
        if (rcd_rdy && col_rdy) begin
          cmd_n              = q_write ? CMD_WR : CMD_RD;
          ba_n               = q_bank;
          addr_n[CW-1:0]     = q_col;
          addr_n[AP_BIT]     = q_ap;
          col_ld             = 1'b1;
          if (q_ap) begin
            clr_en = 1'b1;
            rp_ld  = 1'b1;
            rp_len = half_burst(q_blen) + TW'(T_RP);
          end
          st_n = ST_IDLE;
        end
      end
      ST_RPRE: begin
        if (col_rdy && rp_rdy) begin
          cmd_n          = CMD_PRE;
          addr_n[AP_BIT] = 1'b1;
          rp_ld          = 1'b1;
          clr_all        = 1'b1;
          st_n           = ST_REF;
        end
      end
      ST_REF: begin
        if (rp_rdy && rfc_rdy) begin
          cmd_n   = CMD_REF;
          rfc_ld  = 1'b1;
          ref_ack = 1'b1;
          st_n    = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      q_write <= 1'b0;
      q_ap    <= 1'b0;
      q_bank  <= '0;
      q_row   <= '0;
      q_col   <= '0;
      q_blen  <= '0;
    end else begin
      st     <= st_n;
      cmd_q  <= cmd_n;
      ba_q   <= ba_n;
      addr_q <= addr_n;
      if (accept) begin
        q_write <= req_write;
        q_ap    <= req_autopre;
        q_bank  <= req_bank;
        q_row   <= req_row;
        q_col   <= req_col;
        q_blen  <= req_blen;
      end
    end
  end

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;
  assign cmd_ba   = ba_q;
  assign cmd_addr = addr_q;
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
`timescale 1ns/1ps
module ddr_cmd_seq_chk #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RFC = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_cs_n,
  input logic        cmd_ras_n,
  input logic        cmd_cas_n,
  input logic        cmd_we_n,
  input logic [1:0]  cmd_ba,
  input logic [11:0] cmd_addr
);
  logic [3:0] c;
  assign c = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

  logic is_act, is_col, is_pre, is_ref, is_nop;
  assign is_act = (c == 4'b0011);
  assign is_col = (c == 4'b0101) || (c == 4'b0100);
  assign is_pre = (c == 4'b0010);
  assign is_ref = (c == 4'b0001);
  assign is_nop = (c == 4'b0111);

  logic [7:0] since_act, since_pre, since_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= 8'hff;
      since_pre <= 8'hff;
      since_ref <= 8'hff;
    end else begin
      since_act <= is_act ? 8'd1 : (since_act == 8'hff ? since_act : since_act + 8'd1);
      since_pre <= is_pre ? 8'd1 : (since_pre == 8'hff ? since_pre : since_pre + 8'd1);
      since_ref <= is_ref ? 8'd1 : (since_ref == 8'hff ? since_ref : since_ref + 8'd1);
    end
  end

  assert_reset_nop_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (is_nop && cmd_ba == 2'b00 && cmd_addr == 12'h000));

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    (is_act || is_col || is_pre || is_ref || is_nop));

  assert_act_to_col_R3: assert property (@(posedge clk) disable iff (rst)
    is_col |-> (since_act >= 8'(T_RCD)));

  assert_pre_to_act_R5: assert property (@(posedge clk) disable iff (rst)
    is_act |-> (since_pre >= 8'(T_RP)));

  assert_col_addr_top_R6: assert property (@(posedge clk) disable iff (rst)
    is_col |-> (cmd_addr[11] == 1'b0));

  assert_ref_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !is_nop |-> (since_ref >= 8'(T_RFC)));

  assert_ref_after_pre_R9: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> (since_pre >= 8'(T_RP)));
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst(rst),
  .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
  .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
);

// File: tb/tb_ddr_cmd_seq.sv
`timescale 1ns/1ps
module tb_ddr_cmd_seq;
  localparam int T_RCD = 3;
  localparam int T_RP  = 3;
  localparam int T_RFC = 8;
  localparam int REFI  = 300;

  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_NOP = 4'b0111;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0] req_bank = '0, req_blen = '0;
  logic [11:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic req_ready, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0] cmd_ba;
  logic [11:0] cmd_addr;

  ddr_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .REFI(REFI)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .req_blen(req_blen),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, nlog = 0, nref = 0;
  logic [3:0]  lg_cmd [0:511];
  logic [1:0]  lg_ba  [0:511];
  logic [11:0] lg_addr[0:511];
  int          lg_cyc [0:511];
  int ref_cyc_last = 0, ref_cyc_prev = 0;
  logic ready_after;

  wire [3:0] cmd_now = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst && cmd_now != C_NOP && nlog < 512) begin
      lg_cmd[nlog]  = cmd_now;
      lg_ba[nlog]   = cmd_ba;
      lg_addr[nlog] = cmd_addr;
      lg_cyc[nlog]  = cyc;
      nlog = nlog + 1;
      if (cmd_now == C_REF) begin
        ref_cyc_prev = ref_cyc_last;
        ref_cyc_last = cyc;
        nref = nref + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit w, input logic [1:0] b, input logic [11:0] r,
                      input logic [9:0] c, input bit ap, input logic [1:0] bl);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = b; req_row = r;
    req_col = c; req_autopre = ap; req_blen = bl;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    ready_after = req_ready;
    req_valid = 1'b0;
  endtask

  task automatic sync_ref();
    int n0;
    n0 = nref;
    while (nref == n0) @(negedge clk);
    repeat (T_RFC + 2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (25) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_now == C_NOP, "R1 reset cmd", int'(cmd_now), int'(C_NOP));
    chk(cmd_addr == 0 && cmd_ba == 0, "R1 reset buses", int'(cmd_addr), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
  endtask

  task automatic t_first_ref();
    sync_ref();
    chk(lg_cmd[0] == C_REF, "R9 refresh with all banks closed needs no precharge",
        int'(lg_cmd[0]), int'(C_REF));
  endtask

  task automatic t_closed();
    int i0;
    sync_ref();
    i0 = nlog;
    send(1'b0, 2'd1, 12'h2A7, 10'h13C, 1'b0, 2'd1);
    chk(ready_after == 1'b0, "R10 ready low after accept", int'(ready_after), 0);
    settle();
    chk(nlog == i0 + 2, "R3 command count", nlog - i0, 2);
    chk(lg_cmd[i0] == C_ACT && lg_ba[i0] == 2'd1, "R3 ACTIVE bank", int'(lg_cmd[i0]), int'(C_ACT));
    chk(lg_addr[i0] == 12'h2A7, "R3 ACTIVE row", int'(lg_addr[i0]), 'h2A7);
    chk(lg_cmd[i0+1] == C_RD, "R2 READ code", int'(lg_cmd[i0+1]), int'(C_RD));
    chk(lg_addr[i0+1] == 12'h13C, "R6 column address, no auto-precharge",
        int'(lg_addr[i0+1]), 'h13C);
    chk(lg_cyc[i0+1] - lg_cyc[i0] == T_RCD, "R3 activate-to-column gap",
        lg_cyc[i0+1] - lg_cyc[i0], T_RCD);
  endtask

  task automatic t_hit();
    int i0;
    sync_ref();
    i0 = nlog;
    send(1'b0, 2'd0, 12'h055, 10'h010, 1'b0, 2'd2);
    send(1'b1, 2'd0, 12'h055, 10'h020, 1'b0, 2'd0);
    send(1'b0, 2'd0, 12'h055, 10'h030, 1'b0, 2'd0);
    settle();
    chk(nlog == i0 + 4, "R4 row hit adds no ACTIVE", nlog - i0, 4);
    chk(lg_cmd[i0+2] == C_WR, "R4 hit goes to WRITE", int'(lg_cmd[i0+2]), int'(C_WR));
    chk(lg_cyc[i0+2] - lg_cyc[i0+1] == 4, "R8 BL8 column spacing",
        lg_cyc[i0+2] - lg_cyc[i0+1], 4);
    chk(lg_cmd[i0+3] == C_RD && lg_cyc[i0+3] - lg_cyc[i0+2] >= 1,
        "R8 BL2 column spacing", lg_cyc[i0+3] - lg_cyc[i0+2], 1);
  endtask

  task automatic t_miss();
    int i0;
    sync_ref();
    i0 = nlog;
    send(1'b0, 2'd2, 12'h0A5, 10'h001, 1'b0, 2'd2);
    send(1'b0, 2'd2, 12'h15A, 10'h002, 1'b0, 2'd1);
    settle();
    chk(nlog == i0 + 5, "R5 miss command count", nlog - i0, 5);
    chk(lg_cmd[i0+2] == C_PRE && lg_ba[i0+2] == 2'd2, "R5 PRECHARGE bank",
        int'(lg_cmd[i0+2]), int'(C_PRE));
    chk(lg_addr[i0+2][10] == 1'b0, "R5 single-bank precharge bit 10", int'(lg_addr[i0+2][10]), 0);
    chk(lg_cyc[i0+2] - lg_cyc[i0+1] >= 4, "R8 precharge waits for BL8 burst",
        lg_cyc[i0+2] - lg_cyc[i0+1], 4);
    chk(lg_cmd[i0+3] == C_ACT && lg_addr[i0+3] == 12'h15A, "R5 ACTIVE new row",
        int'(lg_addr[i0+3]), 'h15A);
    chk(lg_cyc[i0+3] - lg_cyc[i0+2] == T_RP, "R5 precharge-to-activate gap",
        lg_cyc[i0+3] - lg_cyc[i0+2], T_RP);
    chk(lg_cyc[i0+4] - lg_cyc[i0+3] == T_RCD, "R5 activate-to-column gap",
        lg_cyc[i0+4] - lg_cyc[i0+3], T_RCD);
  endtask

  task automatic t_autopre();
    int i0;
    sync_ref();
    i0 = nlog;
    send(1'b1, 2'd3, 12'h3C3, 10'h155, 1'b1, 2'd1);
    send(1'b0, 2'd3, 12'h3C3, 10'h0AA, 1'b0, 2'd1);
    settle();
    chk(lg_cmd[i0+1] == C_WR, "R2 WRITE code", int'(lg_cmd[i0+1]), int'(C_WR));
    chk(lg_addr[i0+1] == 12'h555, "R6 auto-precharge in bit 10, column below",
        int'(lg_addr[i0+1]), 'h555);
    chk(lg_cmd[i0+2] == C_ACT, "R7 closed bank reopens with ACTIVE",
        int'(lg_cmd[i0+2]), int'(C_ACT));
    chk(lg_cyc[i0+2] - lg_cyc[i0+1] == 2 + T_RP, "R7 auto-precharge recovery",
        lg_cyc[i0+2] - lg_cyc[i0+1], 2 + T_RP);
    chk(nlog == i0 + 4, "R7 no explicit PRECHARGE", nlog - i0, 4);
  endtask

  task automatic t_refresh_open();
    int i0, k, n0;
    sync_ref();
    send(1'b0, 2'd0, 12'h007, 10'h003, 1'b0, 2'd0);
    n0 = nref;
    while (nref == n0) @(negedge clk);
    k = nlog - 1;
    chk(lg_cmd[k-1] == C_PRE && lg_addr[k-1][10] == 1'b1, "R9 precharge-all before refresh",
        int'(lg_addr[k-1]), 'h400);
    chk(lg_cyc[k] - lg_cyc[k-1] == T_RP, "R9 precharge-all to refresh gap",
        lg_cyc[k] - lg_cyc[k-1], T_RP);
    chk(ref_cyc_last - ref_cyc_prev >= REFI - 5 && ref_cyc_last - ref_cyc_prev <= REFI + 20,
        "R9 refresh interval", ref_cyc_last - ref_cyc_prev, REFI);
    i0 = nlog;
    send(1'b0, 2'd0, 12'h007, 10'h004, 1'b0, 2'd0);
    settle();
    chk(lg_cmd[i0] == C_ACT, "R9 refresh closes banks", int'(lg_cmd[i0]), int'(C_ACT));
    chk(lg_cyc[i0] - ref_cyc_last >= T_RFC, "R9 quiet after refresh",
        lg_cyc[i0] - ref_cyc_last, T_RFC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_first_ref();
    t_closed();
    t_hit();
    t_miss();
    t_autopre();
    t_refresh_open();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule